// File: doc/BRIEF.md
# Fixed-Width Trigger Pulse Generator

The block turns a rising edge on a trigger line into one output pulse whose length is a fixed number of system clock cycles. Two capture paths are available. In the direct path the trigger edge sets a capture flip-flop with no clock involved, so the output rises at once. A two-stage synchronizer carries the captured level into the clock domain. There a small state machine and counter measure out the pulse, then clear the flip-flop to end it. In the filtered path the trigger is first sampled and debounced on the clock, and the output is the state machine's own run interval.

The filter trades leading-edge jitter of up to one clock period for immunity to short glitches. Pulse rejection is part of the design. A trigger that arrives while a pulse is running does not lengthen or restart it. After each pulse the generator re-arms only once the trigger has gone low again. With a 20 MHz clock, a width of 24 cycles gives a 1.2 µs run interval.

Top module: `trig_pulse_gen`

## Requirements
- R1: With the filter off (`flt_en_ni` high), `pulse_o` rises as soon as `trig_i` rises, before any clock edge.
- R2: With the filter off, `pulse_o` stays high through the first `PULSE_CYCLES`+2 rising clock edges after the trigger edge. It falls at edge `PULSE_CYCLES`+3: two edges to synchronize, then `PULSE_CYCLES` counted edges.
- R3: The internal run interval of the state machine lasts exactly `PULSE_CYCLES` clock cycles for every accepted trigger.
- R4: With the filter on (`flt_en_ni` low), `pulse_o` does not rise on the trigger edge itself. It is first seen high after rising edge `FILTER_LEN`+3 from the trigger and stays high for exactly `PULSE_CYCLES` cycles. In this mode the capture flip-flop stays cleared.
- R5: With the filter on, a trigger that is high for fewer than `FILTER_LEN` sampled cycles gives no pulse. One that is high for `FILTER_LEN` or more cycles gives exactly one pulse.
- R6: A trigger that falls and rises again while a pulse is in progress neither lengthens nor restarts it, and gives no later pulse, in either mode.
- R7: A trigger held high past the end of the pulse gives only that one pulse. The generator returns to idle only after the trigger has gone low, and a later rising edge then gives a new pulse.
- R8: While `rst_ni` is low, `pulse_o` is low and the state machine is idle. Asserting reset during a pulse ends it at once, and after release the generator is idle.
- R9: `flt_en_ni` is a static mode select (low = filtered, high = direct) that is changed only while the generator is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger input; rising edge requests a pulse |
| flt_en_ni | input | 1 | Active-low glitch filter enable |
| pulse_o | output | 1 | Fixed-width output pulse |

## Verification
The bound checker watches on every cycle that the run interval never exceeds `PULSE_CYCLES` and ends at exactly that length. It also checks that the re-arm state never jumps back into a run, that the capture flip-flop is cleared during re-arm and in filtered mode, that the filter output only moves to the value just sampled, and that the state is idle when reset is released. The sub-cycle rise of the direct path, the total output width, glitch rejection by length, and the no-restart and held-trigger cases can only be seen from the bench. The bench sweeps trigger hold times exhaustively in both modes and compares the measured high count and first-high cycle with values worked out from the two parameters.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REARM = 2'd2
  } pgen_state_e;

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // run counter reached its programmed end (counter starts at 1)
  function automatic logic run_done(int unsigned cnt, int unsigned width);
    return cnt == width;
  endfunction

  // filter counter has seen len consecutive disagreeing samples
  function automatic logic hold_met(int unsigned cnt, int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgen_capture.sv
module pgen_capture (
  input  logic trig_i,
  input  logic clr_i,
  output logic q_o
);
  // set by the trigger edge itself, cleared asynchronously by the clock domain
  always_ff @(posedge trig_i or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= 1'b1;
  end
endmodule

// File: rtl/pgen_glitch_filter.sv
module pgen_glitch_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic samp_o,
  output logic lvl_o
);
  import pgen_pkg::*;
  localparam int unsigned CW = cnt_bits(LEN);

  logic          samp;
  logic [CW-1:0] hold_q;

  pgen_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (samp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      lvl_o  <= 1'b0;
    end else if (samp != lvl_o) begin
      if (hold_met(int'(hold_q), LEN)) begin
        lvl_o  <= samp;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end else begin
      hold_q <= '0;
    end
  end

  assign samp_o = samp;
endmodule

// File: rtl/pgen_stretch.sv
module pgen_stretch #(
  parameter int unsigned WIDTH = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  quiet_i,
  output logic                  run_o,
  output logic                  clear_o,
  output pgen_pkg::pgen_state_e state_o
);
  import pgen_pkg::*;
  localparam int unsigned CW = cnt_bits(WIDTH);

  pgen_state_e   st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          cnt_q <= CW'(1);
        end
        ST_RUN: if (run_done(int'(cnt_q), WIDTH)) begin
          st_q  <= ST_REARM;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_REARM: if (!start_i && !quiet_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o   = (st_q == ST_RUN);
  assign clear_o = (st_q == ST_REARM);
  assign state_o = st_q;
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 24,
  parameter int unsigned FILTER_LEN   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic flt_en_ni,
  output logic pulse_o
);
  import pgen_pkg::*;

  // named internal events, visible to the bound checker
  logic        filt_mode;
  logic        cap_q;
  logic        cap_s;
  logic        cap_clr;
  logic        samp_lvl;
  logic        filt_lvl;
  logic        start_lvl;
  logic        quiet_lvl;
  logic        run_w;
  logic        clear_w;
  pgen_state_e st_w;

  assign filt_mode = !flt_en_ni;
  assign cap_clr   = !rst_ni || clear_w || filt_mode;

  pgen_capture u_cap (
    .trig_i(trig_i),
    .clr_i (cap_clr),
    .q_o   (cap_q)
  );

  pgen_sync #(.STAGES(2)) u_cap_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_q),
    .q_o   (cap_s)
  );

  pgen_glitch_filter #(.LEN(FILTER_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_i),
    .samp_o(samp_lvl),
    .lvl_o (filt_lvl)
  );

  assign start_lvl = filt_mode ? filt_lvl : cap_s;
  assign quiet_lvl = filt_mode ? filt_lvl : samp_lvl;

  pgen_stretch #(.WIDTH(PULSE_CYCLES)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_lvl),
    .quiet_i(quiet_lvl),
    .run_o  (run_w),
    .clear_o(clear_w),
    .state_o(st_w)
  );

  assign pulse_o = filt_mode ? run_w : cap_q;
endmodule

// File: rtl/trig_pulse_gen_chk.sv
module trig_pulse_gen_chk #(
  parameter int unsigned PULSE_CYCLES = 24
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pulse_o,
  input logic                  filt_mode,
  input logic                  cap_q,
  input logic                  samp_lvl,
  input logic                  filt_lvl,
  input logic                  run_w,
  input pgen_pkg::pgen_state_e st_w
);
  import pgen_pkg::*;
  localparam int unsigned LW = cnt_bits(PULSE_CYCLES + 1);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    len_q <= '0;
    else if (run_w) len_q <= len_q + 1'b1;
    else            len_q <= '0;
  end

  // R3: run never exceeds the width, and ends at exactly the width
  a_r3_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> (len_q < LW'(PULSE_CYCLES)));
  a_r3_run_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_w) |-> (len_q == LW'(PULSE_CYCLES)));

  // R7: re-arm never jumps straight back into a run
  a_r7_rearm_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w == ST_REARM) |=> (st_w != ST_RUN));

  // R2: capture flip-flop is cleared while re-arming
  a_r2_clear_in_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w == ST_REARM) |-> !cap_q);

  // R4: capture path stays cleared in filtered mode
  a_r4_capture_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_mode |-> !cap_q);

  // R5: the filter only moves to the value just sampled
  a_r5_filter_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_lvl) |-> (filt_lvl == $past(samp_lvl)));

  // R8: idle and low on the first cycle after reset release
  a_r8_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ((st_w == ST_IDLE) && !pulse_o));
endmodule

bind trig_pulse_gen trig_pulse_gen_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pulse_o  (pulse_o),
  .filt_mode(filt_mode),
  .cap_q    (cap_q),
  .samp_lvl (samp_lvl),
  .filt_lvl (filt_lvl),
  .run_w    (run_w),
  .st_w     (st_w)
);

// File: tb/trig_pulse_gen_bench.sv
`timescale 1ns/1ps
module trig_pulse_gen_bench;
  localparam int W = 6;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig = 1'b0;
  logic flt_en_n = 1'b1;
  logic pulse;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_pulse_gen #(.PULSE_CYCLES(W), .FILTER_LEN(L)) u_trig_pulse_gen (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .flt_en_ni(flt_en_n),
    .pulse_o  (pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Trigger high from start until after sample a; optionally high again
  // from after sample b until after sample c. Counts high samples.
  task automatic shot(input int a, input int b, input int c,
                      output int n_high, output int first, output int imm);
    int total;
    total = ((c > a) ? c : a) + W + L + 14;
    n_high = 0;
    first = -1;
    @(negedge clk);
    #1 trig = 1'b1;
    #0.5 imm = int'(pulse);
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (pulse) begin
        n_high++;
        if (first < 0) first = k;
      end
      if (k == a) #1 trig = 1'b0;
      if (b > 0 && k == b) #1 trig = 1'b1;
      if (b > 0 && k == c) #1 trig = 1'b0;
    end
    repeat (2 * L + 4) @(negedge clk);
  endtask

  initial begin
    int n, f, im;
    repeat (3) @(negedge clk);
    chk("R8 reset holds output low", int'(pulse), 0);
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle after release", int'(pulse), 0);

    // direct mode: exhaustive hold sweep (R1, R2, R7)
    flt_en_n = 1'b1;
    for (int h = 1; h <= W + 6; h++) begin
      shot(h, 0, 0, n, f, im);
      chk("R1 immediate rise", im, 1);
      chk((h > W + 2) ? "R7 held trigger single pulse width" : "R2 direct width",
          n, W + 2);
      chk("R2 first high sample", f, 1);
    end

    // R6: retrigger during a direct-mode pulse
    shot(1, 3, 4, n, f, im);
    chk("R6 direct retrigger width", n, W + 2);
    shot(2, W, W + 1, n, f, im);
    chk("R6 direct late retrigger width", n, W + 2);

    // R7: held trigger then release, new trigger gives a new pulse
    shot(3 * W, 0, 0, n, f, im);
    chk("R7 held trigger one pulse", n, W + 2);
    shot(1, 0, 0, n, f, im);
    chk("R7 re-armed pulse", n, W + 2);

    // filtered mode: glitch length sweep (R3, R4, R5, R9)
    flt_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int g = 1; g <= L + 4; g++) begin
      shot(g, 0, 0, n, f, im);
      chk("R4 no immediate rise", im, 0);
      if (g < L) begin
        chk("R5 short glitch rejected", n, 0);
      end else begin
        chk("R3 filtered width", n, W);
        chk("R4 filtered first high", f, L + 3);
      end
    end

    // R6 filtered retrigger during run
    shot(L, L + 4, L + 4 + L + 1, n, f, im);
    chk("R6 filtered retrigger width", n, W);

    // R9: back to direct mode while idle
    flt_en_n = 1'b1;
    repeat (4) @(negedge clk);
    shot(1, 0, 0, n, f, im);
    chk("R9 direct mode restored", n, W + 2);
    chk("R9 direct immediate", im, 1);

    // R8: reset in the middle of a direct pulse
    @(negedge clk);
    #1 trig = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b0;
    trig = 1'b0;
    #0.5 chk("R8 reset ends pulse", int'(pulse), 0);
    repeat (2) @(negedge clk);
    #1 rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle after mid-pulse reset", int'(pulse), 0);
    shot(1, 0, 0, n, f, im);
    chk("R8 pulse after reset", n, W + 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule